// File: doc/BRIEF.md
# Distance-Tag Deflection Switching Element

A two-input, two-output switching element for a multistage self-routing fabric in which cells that lose contention are deflected rather than buffered. Each cell carries a routing tag: an n-bit destination address and a distance count. The distance count tells the element which single address bit to examine. A cell whose distance is above zero is steered to one of two interstage links and leaves with its distance reduced by one. A cell whose distance is zero has arrived at its destination row and is handed to one of two local drop outlets. Cells enter the fabric with distance n-1, so the address is consumed from its most significant bit down to bit 0.

When both inlets want the same outlet, the cell with the smaller distance is the one nearer its exit and takes the outlet. Equal distances are settled by a free-running pseudo-random bit. The losing cell is deflected onto the interstage link that was not requested, and its distance is restored to n-1 so that it begins its route again. If the contest is for a drop outlet, neither cell wanted an interstage link, so the loser takes a pseudo-randomly chosen link. Each outlet is registered and carries one cell per cycle with a valid bit. The element never drops a cell.

Top module: `deflectSwitchElement`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every outlet valid bit is 0.
- R2: A lone cell with distance d > 0 appears one cycle later on hop outlet b, where b is address bit d (0 = hop0, 1 = hop1). It leaves with distance d-1 and with its address and payload unchanged.
- R3: A cell with distance 0 appears one cycle later on drop outlet b, where b is address bit 0 (0 = drop0, 1 = drop1), with its address and payload unchanged.
- R4: When two cells request the same hop outlet with different distances, the smaller distance gets that outlet with distance-1. The other cell goes to the other hop outlet with distance n-1.
- R5: When two cells with equal distance request the same hop outlet, exactly one of them gets it with distance-1. The other goes to the other hop outlet with distance n-1.
- R6: When both cells request the same drop outlet, one of them leaves on it. The other leaves on one of the two hop outlets with distance n-1.
- R7: Each valid input cell appears on exactly one outlet in the next cycle, with its payload and address intact. The number of valid outlets equals the number of valid inlets in the previous cycle.
- R8: A drop request and a hop request never contend, even when they examine the same bit value. Both cells take their requested outlets.
- R9: Over a run of equal-distance contests, the tie is not always settled in favour of the same inlet. Each inlet wins at least once in 40 consecutive ties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| in0Valid | input | 1 | Inlet 0 carries a cell |
| in0Addr | input | ADDR_W | Inlet 0 destination address |
| in0Dist | input | DIST_W | Inlet 0 distance count |
| in0Data | input | DATA_W | Inlet 0 payload |
| in1Valid | input | 1 | Inlet 1 carries a cell |
| in1Addr | input | ADDR_W | Inlet 1 destination address |
| in1Dist | input | DIST_W | Inlet 1 distance count |
| in1Data | input | DATA_W | Inlet 1 payload |
| hop0Valid | output | 1 | Interstage link 0 carries a cell |
| hop0Addr | output | ADDR_W | Link 0 address |
| hop0Dist | output | DIST_W | Link 0 updated distance |
| hop0Data | output | DATA_W | Link 0 payload |
| hop1Valid | output | 1 | Interstage link 1 carries a cell |
| hop1Addr | output | ADDR_W | Link 1 address |
| hop1Dist | output | DIST_W | Link 1 updated distance |
| hop1Data | output | DATA_W | Link 1 payload |
| drop0Valid | output | 1 | Local outlet 0 carries a cell |
| drop0Addr | output | ADDR_W | Local outlet 0 address |
| drop0Data | output | DATA_W | Local outlet 0 payload |
| drop1Valid | output | 1 | Local outlet 1 carries a cell |
| drop1Addr | output | ADDR_W | Local outlet 1 address |
| drop1Data | output | DATA_W | Local outlet 1 payload |

## Verification
Arbitration and deflection land in the same cycle whenever both inlets name one outlet. The loser must be steered aside and have its tag rewritten while the winner advances normally. Directed pairs provoke contests on hop links with unequal and equal distances, contests on a drop outlet, and near-misses where a drop request meets a hop request on the same bit. Random pairs then mix all of these. Each outcome is judged by locating every payload on the outlets and confirming that the winner took the requested outlet with the right distance. The loser must sit on the permitted link with distance n-1. When the tie-break is random, either inlet is accepted as the winner.

// File: rtl/seDeflectPkg.sv
package seDeflectPkg;

  // Steering decision for both inlets, one bit per inlet in each field.
  typedef struct packed {
    logic [1:0] grant;    // inlet carries a cell to be placed
    logic [1:0] toLocal;  // place on a drop outlet instead of a hop link
    logic [1:0] side;     // outlet index 0 or 1
    logic [1:0] deflect;  // inlet lost contention, rewrite distance
  } steer_t;

  localparam int SE_PORTS = 2;

endpackage

// File: rtl/seLfsr.sv
module seLfsr #(
  parameter int W    = 8,
  parameter int SEED = 165
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [W-1:0] state
);
  localparam int SEED_MOD = SEED % (1 << W);
  localparam int SEED_NZ  = (SEED_MOD == 0) ? 1 : SEED_MOD;

  logic feedback;

  generate
    if (W == 16) begin : g_w16
      assign feedback = state[15] ^ state[13] ^ state[12] ^ state[10];
    end else if (W == 8) begin : g_w8
      assign feedback = state[7] ^ state[5] ^ state[4] ^ state[3];
    end else begin : g_wn
      assign feedback = state[W-1] ^ state[W-2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= W'(SEED_NZ);
    else       state <= {state[W-2:0], feedback};
  end
endmodule

// File: rtl/seSteerCtrl.sv
module seSteerCtrl
  import seDeflectPkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DIST_W    = 2,
  parameter int LFSR_W    = 8,
  parameter int LFSR_SEED = 165
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             inValid,
  input  logic [1:0][ADDR_W-1:0] inAddr,
  input  logic [1:0][DIST_W-1:0] inDist,
  output steer_t                 steer
);
  logic [LFSR_W-1:0] rnd;
  logic [1:0]        wantLocal;
  logic [1:0]        wantSide;
  logic              clash;
  logic              winner;
  logic              coin;
  logic              spareSide;

  seLfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_rnd (
    .clk   (clk),
    .rstN  (rstN),
    .state (rnd)
  );

  assign coin      = rnd[0];
  assign spareSide = rnd[LFSR_W-1];

  function automatic logic pickBit(input logic [ADDR_W-1:0] a,
                                   input logic [DIST_W-1:0] d);
    logic b;
    b = 1'b0;
    for (int k = 0; k < ADDR_W; k++)
      if (DIST_W'(k) == d) b = a[k];
    return b;
  endfunction

  generate
    for (genvar i = 0; i < SE_PORTS; i++) begin : g_req
      assign wantLocal[i] = (inDist[i] == '0);
      assign wantSide[i]  = pickBit(inAddr[i], inDist[i]);
    end
  endgenerate

  assign clash = (&inValid) && (wantLocal[0] == wantLocal[1])
                            && (wantSide[0] == wantSide[1]);

  always_comb begin
    if (inDist[0] < inDist[1])      winner = 1'b0;
    else if (inDist[1] < inDist[0]) winner = 1'b1;
    else                            winner = coin;
  end

  generate
    for (genvar i = 0; i < SE_PORTS; i++) begin : g_steer
      logic loses;
      assign loses = clash && (winner != 1'(i));
      always_comb begin
        steer.grant[i] = inValid[i];
        if (loses) begin
          steer.deflect[i] = 1'b1;
          steer.toLocal[i] = 1'b0;
          steer.side[i]    = wantLocal[i] ? spareSide : ~wantSide[i];
        end else begin
          steer.deflect[i] = 1'b0;
          steer.toLocal[i] = wantLocal[i];
          steer.side[i]    = wantSide[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/seDeflectDatapath.sv
module seDeflectDatapath
  import seDeflectPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIST_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0][ADDR_W-1:0] inAddr,
  input  logic [1:0][DIST_W-1:0] inDist,
  input  logic [1:0][DATA_W-1:0] inData,
  input  steer_t                 steer,
  output logic [1:0]             hopValid,
  output logic [1:0][ADDR_W-1:0] hopAddr,
  output logic [1:0][DIST_W-1:0] hopDist,
  output logic [1:0][DATA_W-1:0] hopData,
  output logic [1:0]             dropValid,
  output logic [1:0][ADDR_W-1:0] dropAddr,
  output logic [1:0][DATA_W-1:0] dropData
);
  localparam logic [DIST_W-1:0] RESTART = DIST_W'(ADDR_W - 1);

  logic [1:0][DIST_W-1:0] nextDist;

  generate
    for (genvar i = 0; i < SE_PORTS; i++) begin : g_tag
      always_comb begin
        if (steer.deflect[i])      nextDist[i] = RESTART;
        else if (steer.toLocal[i]) nextDist[i] = '0;
        else                       nextDist[i] = inDist[i] - 1'b1;
      end
    end

    for (genvar s = 0; s < SE_PORTS; s++) begin : g_out
      logic [1:0] hopPick;
      logic [1:0] dropPick;
      for (genvar i = 0; i < SE_PORTS; i++) begin : g_pick
        assign hopPick[i]  = steer.grant[i] & ~steer.toLocal[i] & (steer.side[i] == 1'(s));
        assign dropPick[i] = steer.grant[i] &  steer.toLocal[i] & (steer.side[i] == 1'(s));
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hopValid[s]  <= 1'b0;
          hopAddr[s]   <= '0;
          hopDist[s]   <= '0;
          hopData[s]   <= '0;
          dropValid[s] <= 1'b0;
          dropAddr[s]  <= '0;
          dropData[s]  <= '0;
        end else begin
          hopValid[s]  <= |hopPick;
          hopAddr[s]   <= hopPick[1] ? inAddr[1]   : inAddr[0];
          hopDist[s]   <= hopPick[1] ? nextDist[1] : nextDist[0];
          hopData[s]   <= hopPick[1] ? inData[1]   : inData[0];
          dropValid[s] <= |dropPick;
          dropAddr[s]  <= dropPick[1] ? inAddr[1] : inAddr[0];
          dropData[s]  <= dropPick[1] ? inData[1] : inData[0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/deflectSwitchElement.sv
module deflectSwitchElement
  import seDeflectPkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int LFSR_W    = 8,
  parameter int LFSR_SEED = 165,
  localparam int DIST_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              in0Valid,
  input  logic [ADDR_W-1:0] in0Addr,
  input  logic [DIST_W-1:0] in0Dist,
  input  logic [DATA_W-1:0] in0Data,
  input  logic              in1Valid,
  input  logic [ADDR_W-1:0] in1Addr,
  input  logic [DIST_W-1:0] in1Dist,
  input  logic [DATA_W-1:0] in1Data,
  output logic              hop0Valid,
  output logic [ADDR_W-1:0] hop0Addr,
  output logic [DIST_W-1:0] hop0Dist,
  output logic [DATA_W-1:0] hop0Data,
  output logic              hop1Valid,
  output logic [ADDR_W-1:0] hop1Addr,
  output logic [DIST_W-1:0] hop1Dist,
  output logic [DATA_W-1:0] hop1Data,
  output logic              drop0Valid,
  output logic [ADDR_W-1:0] drop0Addr,
  output logic [DATA_W-1:0] drop0Data,
  output logic              drop1Valid,
  output logic [ADDR_W-1:0] drop1Addr,
  output logic [DATA_W-1:0] drop1Data
);
  steer_t                 steer;
  logic [1:0]             hopValid, dropValid;
  logic [1:0][ADDR_W-1:0] hopAddr, dropAddr;
  logic [1:0][DIST_W-1:0] hopDist;
  logic [1:0][DATA_W-1:0] hopData, dropData;

  seSteerCtrl #(
    .ADDR_W(ADDR_W), .DIST_W(DIST_W), .LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid ({in1Valid, in0Valid}),
    .inAddr  ({in1Addr, in0Addr}),
    .inDist  ({in1Dist, in0Dist}),
    .steer   (steer)
  );

  seDeflectDatapath #(
    .ADDR_W(ADDR_W), .DIST_W(DIST_W), .DATA_W(DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .inAddr    ({in1Addr, in0Addr}),
    .inDist    ({in1Dist, in0Dist}),
    .inData    ({in1Data, in0Data}),
    .steer     (steer),
    .hopValid  (hopValid),
    .hopAddr   (hopAddr),
    .hopDist   (hopDist),
    .hopData   (hopData),
    .dropValid (dropValid),
    .dropAddr  (dropAddr),
    .dropData  (dropData)
  );

  assign hop0Valid  = hopValid[0];
  assign hop0Addr   = hopAddr[0];
  assign hop0Dist   = hopDist[0];
  assign hop0Data   = hopData[0];
  assign hop1Valid  = hopValid[1];
  assign hop1Addr   = hopAddr[1];
  assign hop1Dist   = hopDist[1];
  assign hop1Data   = hopData[1];
  assign drop0Valid = dropValid[0];
  assign drop0Addr  = dropAddr[0];
  assign drop0Data  = dropData[0];
  assign drop1Valid = dropValid[1];
  assign drop1Addr  = dropAddr[1];
  assign drop1Data  = dropData[1];
endmodule

// File: rtl/seDeflectChecker.sv
module seDeflectChecker #(
  parameter int ADDR_W = 3,
  parameter int DIST_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              in0Valid,
  input logic [ADDR_W-1:0] in0Addr,
  input logic [DIST_W-1:0] in0Dist,
  input logic [DATA_W-1:0] in0Data,
  input logic              in1Valid,
  input logic [ADDR_W-1:0] in1Addr,
  input logic [DIST_W-1:0] in1Dist,
  input logic [DATA_W-1:0] in1Data,
  input logic              hop0Valid,
  input logic [ADDR_W-1:0] hop0Addr,
  input logic [DIST_W-1:0] hop0Dist,
  input logic [DATA_W-1:0] hop0Data,
  input logic              hop1Valid,
  input logic [ADDR_W-1:0] hop1Addr,
  input logic [DIST_W-1:0] hop1Dist,
  input logic [DATA_W-1:0] hop1Data,
  input logic              drop0Valid,
  input logic [ADDR_W-1:0] drop0Addr,
  input logic [DATA_W-1:0] drop0Data,
  input logic              drop1Valid,
  input logic [ADDR_W-1:0] drop1Addr,
  input logic [DATA_W-1:0] drop1Data
);
  localparam logic [DIST_W-1:0] RESTART = DIST_W'(ADDR_W - 1);

  logic armed;
  logic req0Side, req1Side;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  function automatic logic bitOf(input logic [ADDR_W-1:0] a, input logic [DIST_W-1:0] d);
    logic b;
    b = 1'b0;
    for (int k = 0; k < ADDR_W; k++)
      if (DIST_W'(k) == d) b = a[k];
    return b;
  endfunction

  assign req0Side = bitOf(in0Addr, in0Dist);
  assign req1Side = bitOf(in1Addr, in1Dist);

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !(hop0Valid || hop1Valid || drop0Valid || drop1Valid)); // R1

  AST_CELL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> $countones({hop0Valid, hop1Valid, drop0Valid, drop1Valid})
              == $countones($past({in0Valid, in1Valid}))); // R7

  AST_HOP0_CARRIES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    armed && hop0Valid |->
      ($past(in0Valid) && hop0Data == $past(in0Data) && hop0Addr == $past(in0Addr)) ||
      ($past(in1Valid) && hop0Data == $past(in1Data) && hop0Addr == $past(in1Addr))); // R7

  AST_HOP1_CARRIES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    armed && hop1Valid |->
      ($past(in0Valid) && hop1Data == $past(in0Data) && hop1Addr == $past(in0Addr)) ||
      ($past(in1Valid) && hop1Data == $past(in1Data) && hop1Addr == $past(in1Addr))); // R7

  AST_DROP0_CARRIES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    armed && drop0Valid |->
      ($past(in0Valid) && drop0Data == $past(in0Data)) ||
      ($past(in1Valid) && drop0Data == $past(in1Data))); // R7

  AST_DROP1_CARRIES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    armed && drop1Valid |->
      ($past(in0Valid) && drop1Data == $past(in0Data)) ||
      ($past(in1Valid) && drop1Data == $past(in1Data))); // R7

  AST_DROP0_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    drop0Valid |-> drop0Addr[0] == 1'b0); // R3

  AST_DROP1_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    drop1Valid |-> drop1Addr[0] == 1'b1); // R3

  AST_HOP0_DIST: assert property (@(posedge clk) disable iff (!rstN)
    armed && hop0Valid |-> hop0Dist == RESTART ||
      ({1'b0, hop0Dist} + 1'b1 == {1'b0, $past(in0Dist)}) ||
      ({1'b0, hop0Dist} + 1'b1 == {1'b0, $past(in1Dist)})); // R2

  AST_HOP1_DIST: assert property (@(posedge clk) disable iff (!rstN)
    armed && hop1Valid |-> hop1Dist == RESTART ||
      ({1'b0, hop1Dist} + 1'b1 == {1'b0, $past(in0Dist)}) ||
      ({1'b0, hop1Dist} + 1'b1 == {1'b0, $past(in1Dist)})); // R2

  AST_CLOSER_WINS: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(in0Valid && in1Valid && in0Dist != '0 && in1Dist != '0 &&
                   in0Dist < in1Dist && req0Side == req1Side)
    |-> ($past(req0Side) ? hop1Data : hop0Data) == $past(in0Data)); // R4

endmodule

bind deflectSwitchElement seDeflectChecker #(
  .ADDR_W(ADDR_W), .DIST_W(DIST_W), .DATA_W(DATA_W)
) u_seChecker (.*);

// File: tb/test_deflectSwitchElement.sv
module test_deflectSwitchElement;
  localparam int AW   = 3;
  localparam int DW   = 2;
  localparam int PW   = 8;
  localparam int MAXD = AW - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic in0Valid = 1'b0, in1Valid = 1'b0;
  logic [AW-1:0] in0Addr = '0, in1Addr = '0;
  logic [DW-1:0] in0Dist = '0, in1Dist = '0;
  logic [PW-1:0] in0Data = '0, in1Data = '0;
  logic hop0Valid, hop1Valid, drop0Valid, drop1Valid;
  logic [AW-1:0] hop0Addr, hop1Addr, drop0Addr, drop1Addr;
  logic [DW-1:0] hop0Dist, hop1Dist;
  logic [PW-1:0] hop0Data, hop1Data, drop0Data, drop1Data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tieWins [2];
  int nextPay = 0;

  // captured outlets: slot 0 hop0, 1 hop1, 2 drop0, 3 drop1
  bit      oV [4];
  int      oA [4];
  int      oD [4];
  int      oP [4];
  // stimulus of the cycle under judgement
  bit      sV [2];
  int      sA [2];
  int      sD [2];
  int      sP [2];

  always #5 clk = ~clk;

  deflectSwitchElement i_deflectSwitchElement (
    .clk(clk), .rstN(rstN),
    .in0Valid(in0Valid), .in0Addr(in0Addr), .in0Dist(in0Dist), .in0Data(in0Data),
    .in1Valid(in1Valid), .in1Addr(in1Addr), .in1Dist(in1Dist), .in1Data(in1Data),
    .hop0Valid(hop0Valid), .hop0Addr(hop0Addr), .hop0Dist(hop0Dist), .hop0Data(hop0Data),
    .hop1Valid(hop1Valid), .hop1Addr(hop1Addr), .hop1Dist(hop1Dist), .hop1Data(hop1Data),
    .drop0Valid(drop0Valid), .drop0Addr(drop0Addr), .drop0Data(drop0Data),
    .drop1Valid(drop1Valid), .drop1Addr(drop1Addr), .drop1Data(drop1Data)
  );

  task automatic expectEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int reqSlot(int a, int d);
    if (d == 0) return 2 + (a & 1);
    return (a >> d) & 1;
  endfunction

  function automatic int findSlot(int pay);
    int hit = -1;
    int n = 0;
    for (int s = 0; s < 4; s++)
      if (oV[s] && oP[s] == pay) begin hit = s; n++; end
    if (n > 1) return -2;
    return hit;
  endfunction

  task automatic capture();
    oV[0] = hop0Valid;  oA[0] = int'(hop0Addr);  oD[0] = int'(hop0Dist); oP[0] = int'(hop0Data);
    oV[1] = hop1Valid;  oA[1] = int'(hop1Addr);  oD[1] = int'(hop1Dist); oP[1] = int'(hop1Data);
    oV[2] = drop0Valid; oA[2] = int'(drop0Addr); oD[2] = 0;              oP[2] = int'(drop0Data);
    oV[3] = drop1Valid; oA[3] = int'(drop1Addr); oD[3] = 0;              oP[3] = int'(drop1Data);
  endtask

  // place a pair on the inlets at a falling edge
  task automatic drive(bit v0, int a0, int d0, bit v1, int a1, int d1);
    sV[0] = v0; sA[0] = a0; sD[0] = d0; sP[0] = nextPay % 256;
    sV[1] = v1; sA[1] = a1; sD[1] = d1; sP[1] = (nextPay + 1) % 256;
    nextPay += 2;
    in0Valid = v0; in0Addr = AW'(a0); in0Dist = DW'(d0); in0Data = PW'(sP[0]);
    in1Valid = v1; in1Addr = AW'(a1); in1Dist = DW'(d1); in1Data = PW'(sP[1]);
  endtask

  task automatic checkPlaced(int i, string tag, int expSlot, bit anyHop, int expDist);
    int s;
    s = findSlot(sP[i]);
    if (anyHop) expectEq(tag, "deflected cell on a hop link", int'(s == 0 || s == 1), 1);
    else        expectEq(tag, "outlet slot", s, expSlot);
    if (s >= 0) begin
      expectEq(tag, "address unchanged (R7)", oA[s], sA[i]);
      if (s < 2) expectEq(tag, "distance", oD[s], expDist);
    end
  endtask

  // judge the outlets against the stimulus of the previous cycle
  task automatic judge();
    int nIn, nOut, r0, r1, w, l, s;
    string tag;
    nIn = int'(sV[0]) + int'(sV[1]);
    nOut = 0;
    for (int k = 0; k < 4; k++) nOut += int'(oV[k]);
    expectEq("R7", "valid outlet count", nOut, nIn);
    r0 = reqSlot(sA[0], sD[0]);
    r1 = reqSlot(sA[1], sD[1]);
    if (sV[0] && sV[1] && r0 == r1) begin
      s = r0;
      if (s < 2 && sD[0] != sD[1]) begin
        w = (sD[0] < sD[1]) ? 0 : 1;
        tag = "R4";
      end else begin
        w = (findSlot(sP[0]) == s) ? 0 : 1;
        tag = (s < 2) ? "R5" : "R6";
        if (s < 2) tieWins[w]++;
      end
      l = 1 - w;
      checkPlaced(w, tag, s, 1'b0, sD[w] - 1);
      if (s < 2) checkPlaced(l, tag, 1 - s, 1'b0, MAXD);
      else       checkPlaced(l, tag, -1, 1'b1, MAXD);
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!sV[i]) continue;
        s = (i == 0) ? r0 : r1;
        if (sV[0] && sV[1] && ((r0 >= 2) != (r1 >= 2))) tag = "R8";
        else tag = (s >= 2) ? "R3" : "R2";
        checkPlaced(i, tag, s, 1'b0, sD[i] - 1);
      end
    end
  endtask

  task automatic cycle(bit v0, int a0, int d0, bit v1, int a1, int d1);
    drive(v0, a0, d0, v1, a1, d1);
    @(posedge clk);
    @(negedge clk);
    capture();
    judge();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tieWins[0] = 0; tieWins[1] = 0;
    repeat (3) @(negedge clk);
    capture();
    expectEq("R1", "outlets idle in reset", int'(oV[0] | oV[1] | oV[2] | oV[3]), 0);
    rstN = 1'b1;
    @(negedge clk);
    capture();
    expectEq("R1", "outlets idle after release", int'(oV[0] | oV[1] | oV[2] | oV[3]), 0);

    // R2: lone cells on hop links, bit indexed by distance
    cycle(1, 3'b100, 2, 0, 0, 0);
    cycle(0, 0, 0, 1, 3'b001, 1);
    cycle(1, 3'b010, 1, 0, 0, 0);
    // R3: distance zero to drop outlets
    cycle(1, 3'b011, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 3'b110, 0);
    // R4: unequal distances, both sides winning
    cycle(1, 3'b100, 2, 1, 3'b010, 1);
    cycle(1, 3'b000, 1, 1, 3'b011, 2);
    // R6: both want drop1, then drop0
    cycle(1, 3'b001, 0, 1, 3'b111, 0);
    cycle(1, 3'b010, 0, 1, 3'b100, 0);
    // R8: drop request and hop request on same bit value
    cycle(1, 3'b000, 0, 1, 3'b000, 1);
    cycle(1, 3'b110, 2, 1, 3'b101, 0);
    // R5 / R9: run of equal-distance ties
    for (int k = 0; k < 40; k++) begin
      int a0, a1;
      a0 = $urandom_range(0, 3);
      a1 = $urandom_range(0, 3);
      if (k % 2 == 1) begin a0 += 4; a1 += 4; end
      cycle(1, a0, 2, 1, a1, 2);
    end
    expectEq("R9", "inlet 0 won a tie", int'(tieWins[0] > 0), 1);
    expectEq("R9", "inlet 1 won a tie", int'(tieWins[1] > 0), 1);
    // random mix of all cases (R2..R8)
    for (int k = 0; k < 600; k++) begin
      cycle(bit'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, MAXD),
            bit'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, MAXD));
    end
    cycle(0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule